// File: doc/BRIEF.md
# Muxed Two-Stage Clock Divider

This block produces the clock for a small management co-processor. One of four free-running source clocks is picked by a select field. The picked clock then goes through a power-of-two prescaler, and after that through an integer divider that divides by N+1. The block drives the divided clock out together with a strobe that is high for one source cycle per output period.

All three controls live in one 32-bit configuration word in the register clock domain. The word has two write enables. One enable updates only the source select. The other updates only the two rate fields. The word is always readable.

A source change uses a handshaked, glitch-free handover between the clocks. A rate change waits for the current output period to finish before it takes effect. Software can therefore reprogram the clock while the co-processor keeps running on it.

Top module: `mgmt_clkgen`

## Requirements
- R1: After reset the configuration word reads 0x00000000, and the output follows source 0 undivided (one output period per source-0 cycle).
- R2: Bits [17:16] of the word select the source clock. The output period is counted in cycles of the selected source.
- R3: Bits [5:4] hold a prescaler shift s from 0 to 3. The selected clock is divided by 2^s ahead of the integer divider.
- R4: Bits [12:8] hold N from 0 to 31. Every output period lasts exactly (N+1)·2^s selected-source cycles, so the range is 1 to 256.
- R5: A pulse on selWe loads only bits [17:16] from wrData. A pulse on rateWe loads only bits [5:4] and [12:8]. Every other bit of the word reads back as zero.
- R6: A source change never produces an output high or low phase shorter than half a period of the faster of the two clocks involved. At no time are two sources enabled together.
- R7: A new shift or N value takes effect only when the output period in progress completes. The period in progress keeps its old length and the following period has the new length.
- R8: When the period P is greater than 1, the output is high for ceil(P/2) source cycles and low for the rest, starting high. When P is 1, the output is the selected source itself.
- R9: divStrobe is high for exactly one selected-source cycle per output period, the first one. When P is 1 it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-port clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcClk | input | 4 | Candidate source clocks, bit i is source i |
| selWe | input | 1 | Write strobe for the source select field |
| rateWe | input | 1 | Write strobe for the shift and N fields |
| wrData | input | 32 | Write data, laid out like the configuration word |
| rdData | output | 32 | Current configuration word |
| divClk | output | 1 | Divided output clock |
| divStrobe | output | 1 | One-source-cycle enable at the start of each output period |

## Verification
The bench measures every output period and high phase by counting negative edges of the selected source. It covers odd periods, where rounding the high phase the wrong way shows up as a wrong high count, and the 256-cycle maximum, where a counter one bit too narrow would wrap early.

Source switches run in pass-through mode while a monitor tracks the width of every output pulse. A mux that lets go of the old clock or grabs the new one on the wrong edge leaves a sliver shorter than any source half period.

A rate change is written in the middle of a long period. A divider that reloads immediately would cut that period short instead of finishing it at the old length. Writes of all ones through each enable expose any field that leaks across enables and any unused bit that is not tied to zero.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  localparam int NUM_SRC   = 4;
  localparam int SEL_W     = $clog2(NUM_SRC);
  localparam int SHIFT_W   = 2;
  localparam int DIVN_W    = 5;
  localparam int REG_W     = 32;
  // field positions in the configuration word
  localparam int SEL_LSB   = 16;
  localparam int SHIFT_LSB = 4;
  localparam int DIVN_LSB  = 8;
  // prescaler counter covers 2^(2^SHIFT_W - 1) states
  localparam int PRE_W     = (1 << SHIFT_W) - 1;
  localparam int POS_W     = DIVN_W + PRE_W;

  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [SHIFT_W-1:0] shift;
    logic [DIVN_W-1:0]  divN;
  } clkCfg_t;
endpackage

// File: rtl/clkgen_regs.sv
`timescale 1ns/1ps
module clkgen_regs
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWe,
  input  logic             rateWe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output clkCfg_t          cfg
);
  logic [SEL_W-1:0]   selQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic [DIVN_W-1:0]  divNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      shiftQ <= '0;
      divNQ  <= '0;
    end else begin
      if (selWe) selQ <= wrData[SEL_LSB +: SEL_W];
      if (rateWe) begin
        shiftQ <= wrData[SHIFT_LSB +: SHIFT_W];
        divNQ  <= wrData[DIVN_LSB +: DIVN_W];
      end
    end
  end

  always_comb begin
    rdData = '0;
    rdData[SEL_LSB +: SEL_W]     = selQ;
    rdData[SHIFT_LSB +: SHIFT_W] = shiftQ;
    rdData[DIVN_LSB +: DIVN_W]   = divNQ;
  end

  assign cfg = '{sel: selQ, shift: shiftQ, divN: divNQ};

  // R5
  sel_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selWe && !rateWe) |=> ($stable(shiftQ) && $stable(divNQ)));
  // R5
  rate_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateWe && !selWe) |=> $stable(selQ));
endmodule

// File: rtl/clkgen_srcmux.sv
`timescale 1ns/1ps
module clkgen_srcmux
  import clkgen_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic            rstN,
  input  logic [NSRC-1:0] srcClk,
  input  logic [SW-1:0]   sel,
  output logic [NSRC-1:0] enVec,
  output logic            muxClk
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic syncA, syncB, enQ, othersOn;
    assign othersOn = |(enVec & ~(NSRC'(1) << i));

    always_ff @(posedge srcClk[i] or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
      end else begin
        syncA <= (sel == SW'(i)) && !othersOn;
        syncB <= syncA;
      end
    end

    // the enable changes only while this source is low
    always_ff @(negedge srcClk[i] or negedge rstN) begin
      if (!rstN) enQ <= 1'b0;
      else       enQ <= syncB;
    end

    assign enVec[i] = enQ;
  end

  assign muxClk = |(srcClk & enVec);
endmodule

// File: rtl/clkgen_divider.sv
`timescale 1ns/1ps
module clkgen_divider
  import clkgen_pkg::*;
(
  input  logic    muxClk,
  input  logic    rstN,
  input  clkCfg_t cfg,
  output logic    divClk,
  output logic    divStrobe
);
  localparam int RATE_W = SHIFT_W + DIVN_W;

  logic [RATE_W-1:0]  rateS1, rateS2, rateS3;
  logic               rateSteady;
  logic [SHIFT_W-1:0] curShift, nextShift;
  logic [DIVN_W-1:0]  curN, nextN;
  logic [PRE_W-1:0]   preCnt, preNext, preMask;
  logic [DIVN_W-1:0]  divCnt, divNext;
  logic               preEnd, wrap;
  logic [POS_W-1:0]   nextPos;
  logic [POS_W:0]     periodLen, halfLen;
  logic               divQ, strobeQ, bypassQ;

  always_ff @(posedge muxClk or negedge rstN) begin
    if (!rstN) begin
      rateS1 <= '0;
      rateS2 <= '0;
      rateS3 <= '0;
    end else begin
      rateS1 <= {cfg.shift, cfg.divN};
      rateS2 <= rateS1;
      rateS3 <= rateS2;
    end
  end
  assign rateSteady = (rateS2 == rateS3);

  always_comb begin
    preMask = ~({PRE_W{1'b1}} << curShift);
    preEnd  = (preCnt == preMask);
    wrap    = preEnd && (divCnt == curN);
    nextShift = curShift;
    nextN     = curN;
    if (wrap) begin
      preNext = '0;
      divNext = '0;
      if (rateSteady) {nextShift, nextN} = rateS3;
    end else if (preEnd) begin
      preNext = '0;
      divNext = divCnt + DIVN_W'(1);
    end else begin
      preNext = preCnt + PRE_W'(1);
      divNext = divCnt;
    end
    nextPos   = (POS_W'(divNext) << nextShift) | POS_W'(preNext);
    periodLen = ((POS_W+1)'(nextN) + (POS_W+1)'(1)) << nextShift;
    halfLen   = (periodLen + (POS_W+1)'(1)) >> 1;
  end

  always_ff @(posedge muxClk or negedge rstN) begin
    if (!rstN) begin
      curShift <= '0;
      curN     <= '0;
      preCnt   <= '0;
      divCnt   <= '0;
      divQ     <= 1'b1;
      strobeQ  <= 1'b1;
      bypassQ  <= 1'b1;
    end else begin
      curShift <= nextShift;
      curN     <= nextN;
      preCnt   <= preNext;
      divCnt   <= divNext;
      divQ     <= ((POS_W+1)'(nextPos) < halfLen);
      strobeQ  <= (nextPos == '0);
      bypassQ  <= (periodLen == (POS_W+1)'(1));
    end
  end

  assign divClk    = bypassQ ? muxClk : divQ;
  assign divStrobe = strobeQ;

  // R7
  hold_cfg_chk: assert property (@(posedge muxClk) disable iff (!rstN)
    !wrap |=> ($stable(curN) && $stable(curShift)));
  // R9
  strobe_pulse_chk: assert property (@(posedge muxClk) disable iff (!rstN)
    (strobeQ && !bypassQ) |=> !strobeQ);
  // R4
  cnt_range_chk: assert property (@(posedge muxClk) disable iff (!rstN)
    (divCnt <= curN) && (preCnt <= preMask));
endmodule

// File: rtl/mgmt_clkgen.sv
`timescale 1ns/1ps
module mgmt_clkgen
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       srcClk,
  input  logic             selWe,
  input  logic             rateWe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             divClk,
  output logic             divStrobe
);
  clkCfg_t            cfg;
  logic [NUM_SRC-1:0] enVec;
  logic               muxClk;

  clkgen_regs u_regs (
    .clk(clk), .rstN(rstN), .selWe(selWe), .rateWe(rateWe),
    .wrData(wrData), .rdData(rdData), .cfg(cfg)
  );

  clkgen_srcmux #(.NSRC(NUM_SRC)) u_mux (
    .rstN(rstN), .srcClk(srcClk), .sel(cfg.sel),
    .enVec(enVec), .muxClk(muxClk)
  );

  clkgen_divider u_div (
    .muxClk(muxClk), .rstN(rstN), .cfg(cfg),
    .divClk(divClk), .divStrobe(divStrobe)
  );

  // R6
  onehot_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(enVec));
endmodule

// File: tb/mgmt_clkgen_test.sv
`timescale 1ns/1ps
module mgmt_clkgen_test;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        s0 = 0, s1 = 0, s2 = 0, s3 = 0;
  logic [3:0]  srcClk;
  logic        selWe = 0, rateWe = 0;
  logic [31:0] wrData = '0, rdData;
  logic        divClk, divStrobe;
  int          checks = 0, errors = 0;
  int          negCnt [4];
  int          strbCnt [4];
  bit          monOn = 0;
  int          glitchCnt = 0;
  realtime     lastEdge = 0;

  assign srcClk = {s3, s2, s1, s0};

  always #2.5 clk = ~clk;
  always #4   s0 = ~s0;
  always #6   s1 = ~s1;
  always #9   s2 = ~s2;
  always #13  s3 = ~s3;

  mgmt_clkgen uut (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .selWe(selWe), .rateWe(rateWe),
    .wrData(wrData), .rdData(rdData), .divClk(divClk), .divStrobe(divStrobe)
  );

  initial for (int k = 0; k < 4; k++) begin negCnt[k] = 0; strbCnt[k] = 0; end

  for (genvar k = 0; k < 4; k++) begin : g_cnt
    always @(negedge srcClk[k]) begin
      negCnt[k] = negCnt[k] + 1;
      if (divStrobe) strbCnt[k] = strbCnt[k] + 1;
    end
  end

  always @(divClk) begin
    if (monOn && rstN && ($realtime - lastEdge) < 3.9) glitchCnt++;
    lastEdge = $realtime;
  end

  function automatic logic [31:0] rateWord(input int sh, input int n);
    return (32'(n) << 8) | (32'(sh) << 4);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrSel(input logic [31:0] d);
    @(negedge clk); wrData = d; selWe = 1;
    @(negedge clk); selWe = 0;
  endtask

  task automatic wrRate(input logic [31:0] d);
    @(negedge clk); wrData = d; rateWe = 1;
    @(negedge clk); rateWe = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge divClk);
  endtask

  task automatic measure(input int idx, input int expP, input string req);
    int a, sa, h, p, s;
    @(posedge divClk); a = negCnt[idx]; sa = strbCnt[idx];
    @(negedge divClk); h = negCnt[idx] - a;
    @(posedge divClk); p = negCnt[idx] - a; s = strbCnt[idx] - sa;
    check(p == expP, req, "period", p, expP);
    if (expP > 1) check(h == (expP + 1) / 2, "R8", "high phase", h, (expP + 1) / 2);
    check(s == 1, "R9", "strobes per period", s, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rdData == 32'h0, "R1", "reset word", rdData, 0);
    settle();
    measure(0, 1, "R1");
  endtask

  task automatic t_rate(input int sh, input int n, input string req);
    wrRate(rateWord(sh, n));
    @(negedge clk);
    check(rdData == rateWord(sh, n), "R5", "rate readback", rdData, rateWord(sh, n));
    settle();
    measure(0, (n + 1) << sh, req);
  endtask

  task automatic t_fields();
    wrRate(32'hFFFF_FFFF); @(negedge clk);
    check(rdData == 32'h0000_1F30, "R5", "rate write all ones", rdData, 32'h0000_1F30);
    wrSel(32'hFFFF_FFFF); @(negedge clk);
    check(rdData == 32'h0003_1F30, "R5", "select write all ones", rdData, 32'h0003_1F30);
    wrRate(32'h0); @(negedge clk);
    check(rdData == 32'h0003_0000, "R5", "rate clear keeps select", rdData, 32'h0003_0000);
    wrSel(32'h0); @(negedge clk);
    check(rdData == 32'h0, "R5", "select clear", rdData, 0);
    #400; settle();
  endtask

  task automatic t_switch();
    int order [4] = '{1, 3, 2, 0};
    monOn = 1;
    foreach (order[i]) begin
      wrSel(32'(order[i]) << 16);
      #400; settle();
      measure(order[i], 1, "R2");
    end
    monOn = 0;
    check(glitchCnt == 0, "R6", "short pulses during switching", glitchCnt, 0);
    wrRate(rateWord(1, 2));
    wrSel(32'h0002_0000); #400; settle();
    measure(2, 6, "R2");
    wrSel(32'h0003_0000); #400; settle();
    measure(3, 6, "R2");
    wrSel(32'h0); #400; settle();
  endtask

  task automatic t_runt();
    int a, b, c;
    wrRate(rateWord(2, 4)); settle();
    @(posedge divClk); a = negCnt[0];
    repeat (10) @(negedge clk);
    wrRate(rateWord(1, 2));
    @(posedge divClk); b = negCnt[0];
    @(posedge divClk); c = negCnt[0];
    check(b - a == 20, "R7", "period in progress", b - a, 20);
    check(c - b == 6, "R7", "first new period", c - b, 6);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50; @(negedge clk); rstN = 1;
    t_reset();
    t_rate(1, 0, "R3");
    t_rate(2, 0, "R3");
    t_rate(0, 2, "R4");
    t_rate(0, 4, "R8");
    t_rate(2, 4, "R4");
    t_rate(0, 31, "R4");
    t_rate(3, 31, "R4");
    t_rate(0, 0, "R8");
    t_fields();
    t_switch();
    t_runt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule